// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the command interface of a parallel NOR flash with a byte or word data bus. It watches the bus strobes (active-low chip enable, write enable and output enable) with the address and data lines. It recognises unlock-keyed command sequences of several cycles and moves between three working modes: reading the array, reading the identifier, and a self-timed chip erase. A small register file stands in for the memory array, so the effect of an erase can be read back over the bus.

A write is taken on the clock edge where write enable is seen high after having been low while chip enable is low. A read cycle is any clock cycle with chip enable and output enable low and write enable high. Its result appears on `rdData` after that edge and holds until the next read. While an erase is running or has failed, reads return a status byte in place of array data.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the block is in array-read mode, `readyOut` is 1, and array word i holds 16'hA500 + i.
- R2: In array-read mode a read returns the word at `addr[3:0]`. With `wordMode` = 0 only the low byte is returned and bits 15:8 read 0.
- R3: The writes 555h/AAh, 2AAh/55h, 555h/90h (address/data) enter identifier-read mode. There `addr[1:0]` = 0 reads 00C2h, `addr[1:0]` = 1 reads 2249h, and any other value reads 0. Byte mode keeps the low byte only (C2h, 49h).
- R4: In identifier-read mode, every write whose data is not F0h is ignored and the mode is kept.
- R5: A write with data F0h returns the block to array-read mode and clears any partial sequence. This holds in identifier-read mode, in the failed-erase state and part way through a sequence. It has no effect while an erase is still running.
- R6: In array-read mode, a write that does not match the next expected step of a sequence drops the partial sequence. A later complete sequence is then decoded normally.
- R7: The six writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h, 555h/10h start a chip erase. `readyOut` goes low in the cycle after the final write is taken.
- R8: While the erase runs, a read returns bit 7 = 0, bit 6 inverted from the previous status read, and all other bits 0.
- R9: Writes are ignored while the erase runs. ERASE_CYC cycles after it starts (with `forceTimeout` low), every word becomes all ones, `readyOut` goes high and the block is in array-read mode, so bit 7 then reads 1.
- R10: The erase first sets every array word to zero in the cycle after it starts.
- R11: While `forceTimeout` is 1 the erase cannot complete. TIMEOUT_CYC cycles after the start, status reads return bit 5 = 1 and bit 7 = 0, and `readyOut` stays low until an F0h write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low; a write is taken when it returns high |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| wrData | input | 8 | Command data byte |
| wordMode | input | 1 | 1 = 16-bit reads, 0 = byte reads |
| forceTimeout | input | 1 | Test input that holds off erase completion |
| rdData | output | DATA_W | Read data or status |
| readyOut | output | 1 | 1 = ready, 0 = busy |

## Verification
On every cycle the assertions check the following. An erase-start write drops ready in the next cycle. Ready stays low until the erase count has run out. A forced timeout keeps the erase state alive until its limit. Identifier mode survives any write other than reset. The clear and fill strobes reach the array, and a status read during the erase shows bit 7 low. Other behaviour can only be shown by the bench's scenarios: bit 6 alternating across successive status reads, the exact codes returned in each mode and width, sequences broken at random points and then completed, and the all-zero array left behind by a forced timeout.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_IDREAD = 2'd1,
    MODE_ERASE  = 2'd2,
    MODE_FAIL   = 2'd3
  } modeT;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_KEY1  = 3'd1,
    SEQ_KEY2  = 3'd2,
    SEQ_SETUP = 3'd3,
    SEQ_EKEY1 = 3'd4,
    SEQ_EKEY2 = 3'd5
  } seqT;

  // strobes from control to datapath
  typedef struct packed {
    logic clearArr;
    logic fillArr;
  } strobeT;

  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  OP_IDENT   = 8'h90;
  localparam logic [7:0]  OP_SETUP   = 8'h80;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [7:0]  OP_RESET   = 8'hF0;
  localparam logic [11:0] ADDR_KEYA  = 12'h555;
  localparam logic [11:0] ADDR_KEYB  = 12'h2AA;

endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int ERASE_CYC   = 40,
  parameter int TIMEOUT_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              forceTimeout,
  output modeT              mode,
  output strobeT            strb,
  output logic              readyOut
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_ERASE = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] LAST_LIMIT = CNT_W'(TIMEOUT_CYC - 1);

  logic            weNq;
  logic            wrFire;
  logic [11:0]     lowAddr;
  logic            isKeyA, isKeyB, isReset;
  seqT             seq, nextSeq;
  modeT            nextMode;
  logic            startErase;
  logic [CNT_W-1:0] cnt;
  logic            eraseDone, eraseLimit;

  assign lowAddr = addr[11:0];
  assign wrFire  = weN && !weNq && !ceN;
  assign isKeyA  = (lowAddr == ADDR_KEYA);
  assign isKeyB  = (lowAddr == ADDR_KEYB);
  assign isReset = (wrData == OP_RESET);

  always_ff @(posedge clk) begin
    if (!rstN) weNq <= 1'b1;
    else       weNq <= weN;
  end

  // sequence decode
  always_comb begin
    nextSeq    = seq;
    nextMode   = mode;
    startErase = 1'b0;
    if (wrFire) begin
      unique case (mode)
        MODE_ARRAY: begin
          if (isReset) nextSeq = SEQ_IDLE;
          else begin
            nextSeq = SEQ_IDLE;
            unique case (seq)
              SEQ_IDLE:  if (isKeyA && wrData == KEY_FIRST)  nextSeq = SEQ_KEY1;
              SEQ_KEY1:  if (isKeyB && wrData == KEY_SECOND) nextSeq = SEQ_KEY2;
              SEQ_KEY2: begin
                if (isKeyA && wrData == OP_IDENT)      nextMode = MODE_IDREAD;
                else if (isKeyA && wrData == OP_SETUP) nextSeq  = SEQ_SETUP;
              end
              SEQ_SETUP: if (isKeyA && wrData == KEY_FIRST)  nextSeq = SEQ_EKEY1;
              SEQ_EKEY1: if (isKeyB && wrData == KEY_SECOND) nextSeq = SEQ_EKEY2;
              SEQ_EKEY2: if (isKeyA && wrData == OP_CHIP)    startErase = 1'b1;
              default:   nextSeq = SEQ_IDLE;
            endcase
          end
        end
        MODE_IDREAD, MODE_FAIL: if (isReset) nextMode = MODE_ARRAY;
        default: ;
      endcase
    end
  end

  assign eraseDone  = (mode == MODE_ERASE) && (cnt >= LAST_ERASE) && !forceTimeout;
  assign eraseLimit = (mode == MODE_ERASE) && (cnt == LAST_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode <= MODE_ARRAY;
      seq  <= SEQ_IDLE;
      cnt  <= '0;
    end else begin
      seq <= nextSeq;
      if (startErase) begin
        mode <= MODE_ERASE;
        cnt  <= '0;
      end else if (mode == MODE_ERASE) begin
        if (eraseDone)       mode <= MODE_ARRAY;
        else if (eraseLimit) mode <= MODE_FAIL;
        else                 cnt  <= cnt + 1'b1;
      end else begin
        mode <= nextMode;
      end
    end
  end

  assign strb.clearArr = (mode == MODE_ERASE) && (cnt == '0);
  assign strb.fillArr  = eraseDone;
  assign readyOut      = (mode == MODE_ARRAY) || (mode == MODE_IDREAD);

  // R7
  erase_start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ARRAY && seq == SEQ_EKEY2 && wrFire && isKeyA && wrData == OP_CHIP)
      |=> !readyOut);

  // R4
  idread_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_IDREAD && wrFire && wrData != OP_RESET) |=> (mode == MODE_IDREAD));

  // R9
  erase_busy_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ERASE && cnt < LAST_ERASE) |=> !readyOut);

  // R11
  timeout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ERASE && forceTimeout && cnt < LAST_LIMIT) |=> (mode == MODE_ERASE));

endmodule

// File: rtl/nor_cmd_datapath.sv
module nor_cmd_datapath
  import nor_cmd_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          DEPTH     = 16,
  parameter logic [15:0] MFR_CODE  = 16'h00C2,
  parameter logic [15:0] DEV_CODE  = 16'h2249,
  parameter logic [15:0] INIT_BASE = 16'hA500
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ceN,
  input  logic                     weN,
  input  logic                     oeN,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic                     wordMode,
  input  modeT                     mode,
  input  strobeT                   strb,
  output logic [DATA_W-1:0]        rdData
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] arr [DEPTH];
  logic [DATA_W-1:0] muxVal, statusWord;
  logic              toggleBit;
  logic              rdFire;
  logic              isStatus;

  assign rdFire   = !ceN && !oeN && weN;
  assign isStatus = (mode == MODE_ERASE) || (mode == MODE_FAIL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= DATA_W'(INIT_BASE + 16'(i));
    end else if (strb.clearArr) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
    end else if (strb.fillArr) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '1;
    end
  end

  always_comb begin
    statusWord    = '0;
    statusWord[6] = toggleBit;
    statusWord[5] = (mode == MODE_FAIL);
  end

  always_comb begin
    unique case (mode)
      MODE_ARRAY:  muxVal = arr[rdAddr];
      MODE_IDREAD: begin
        if (rdAddr[1:0] == 2'd0)      muxVal = DATA_W'(MFR_CODE);
        else if (rdAddr[1:0] == 2'd1) muxVal = DATA_W'(DEV_CODE);
        else                          muxVal = '0;
      end
      default:     muxVal = statusWord;
    endcase
    if (!wordMode) muxVal[DATA_W-1:8] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      toggleBit <= 1'b0;
    end else if (rdFire) begin
      rdData <= muxVal;
      if (isStatus) toggleBit <= ~toggleBit;
    end
  end

  // R10
  preprogram_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearArr |=> (arr[0] == '0 && arr[DEPTH-1] == '0));

  // R9
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillArr |=> (arr[0] == '1 && arr[DEPTH-1] == '1));

  // R8
  status_busy_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdFire && mode == MODE_ERASE) |=> (rdData[7] == 1'b0 && rdData[4:0] == '0));

  initial begin
    if (IDX_W < 2) $error("DEPTH too small for identifier select");
  end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 16,
  parameter int ERASE_CYC   = 40,
  parameter int TIMEOUT_CYC = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wordMode,
  input  logic              forceTimeout,
  output logic [DATA_W-1:0] rdData,
  output logic              readyOut
);

  localparam int IDX_W = $clog2(DEPTH);

  modeT   mode;
  strobeT strb;

  nor_cmd_ctrl #(
    .ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .addr(addr),
    .wrData(wrData), .forceTimeout(forceTimeout),
    .mode(mode), .strb(strb), .readyOut(readyOut)
  );

  nor_cmd_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .rdAddr(addr[IDX_W-1:0]), .wordMode(wordMode),
    .mode(mode), .strb(strb), .rdData(rdData)
  );

endmodule

// File: tb/nor_cmd_decoder_tb.sv
module nor_cmd_decoder_tb;

  localparam int ADDR_W = 12, DATA_W = 16, DEPTH = 16;
  localparam int ERASE_CYC = 40, TIMEOUT_CYC = 100;

  logic clk = 1'b0, rstN = 1'b0, ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic wordMode = 1'b1, forceTimeout = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic readyOut;

  int total = 0, bad = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  nor_cmd_decoder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .ERASE_CYC(ERASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .wrData(wrData), .wordMode(wordMode), .forceTimeout(forceTimeout),
    .rdData(rdData), .readyOut(readyOut)
  );

  function automatic logic [15:0] widthMask(input logic [15:0] v, input logic wm);
    return wm ? v : {8'h00, v[7:0]};
  endfunction

  function automatic logic [15:0] idExpect(input int a, input logic wm);
    logic [15:0] v;
    v = (a % 4 == 0) ? 16'h00C2 : (a % 4 == 1) ? 16'h2249 : 16'h0000;
    return widthMask(v, wm);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; addr = a; wrData = d;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); ceN = 1'b1;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; addr = a;
    @(negedge clk); d = rdData; oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic eraseSeq();
    busWrite(12'h555, 8'hAA); busWrite(12'h2AA, 8'h55); busWrite(12'h555, 8'h80);
    busWrite(12'h555, 8'hAA); busWrite(12'h2AA, 8'h55); busWrite(12'h555, 8'h10);
  endtask

  task automatic idSeq();
    busWrite(12'h555, 8'hAA); busWrite(12'h2AA, 8'h55); busWrite(12'h555, 8'h90);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=finished");
    finishRun();
  end

  initial begin
    logic [15:0] d, prev;
    logic [7:0] junk;
    int polls;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hA500 + 16'(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ready", {31'b0, readyOut}, 32'd1);
    for (int i = 0; i < DEPTH; i++) begin
      busRead(12'(i), d);
      check("R1 init word", {16'b0, d}, {16'b0, model[i]});
    end

    // R2 random reads, both widths
    for (int n = 0; n < 30; n++) begin
      int a;
      a = $urandom % DEPTH;
      wordMode = $urandom % 2;
      busRead(12'(a), d);
      check("R2 array read", {16'b0, d}, {16'b0, widthMask(model[a], wordMode)});
    end
    wordMode = 1'b1;

    // R3 identifier mode
    idSeq();
    for (int n = 0; n < 12; n++) begin
      int a;
      a = $urandom % DEPTH;
      wordMode = $urandom % 2;
      busRead(12'(a), d);
      check("R3 id read", {16'b0, d}, {16'b0, idExpect(a, wordMode)});
    end
    wordMode = 1'b1;
    busRead(12'h000, d); check("R3 mfr word", {16'b0, d}, 32'h00C2);
    busRead(12'h001, d); check("R3 dev word", {16'b0, d}, 32'h2249);

    // R4 ignored writes in identifier mode
    busWrite(12'h555, 8'hAA); busWrite(12'h2AA, 8'h55); busWrite(12'h555, 8'h80);
    busRead(12'h001, d); check("R4 id kept", {16'b0, d}, 32'h2249);
    check("R4 ready kept", {31'b0, readyOut}, 32'd1);

    // R5 reset command leaves identifier mode
    busWrite(12'h123, 8'hF0);
    busRead(12'h003, d); check("R5 back to array", {16'b0, d}, {16'b0, model[3]});
    // R5 reset mid-sequence
    busWrite(12'h555, 8'hAA); busWrite(12'h2AA, 8'h55); busWrite(12'h555, 8'hF0);
    busWrite(12'h555, 8'h90);
    busRead(12'h000, d); check("R5 mid-seq reset", {16'b0, d}, {16'b0, model[0]});

    // R6 broken sequences at random points
    for (int n = 0; n < 16; n++) begin
      junk = 8'($urandom);
      if (junk == 8'h55) junk = 8'h56;
      busWrite(12'h555, 8'hAA);
      busWrite(12'h2AA, junk);
      busWrite(12'h555, 8'h90);
      busRead(12'h000, d);
      check("R6 broken seq", {16'b0, d}, {16'b0, model[0]});
    end
    idSeq();
    busRead(12'h000, d); check("R6 seq after break", {16'b0, d}, 32'h00C2);
    busWrite(12'h000, 8'hF0);

    // R7 erase start
    eraseSeq();
    check("R7 busy after start", {31'b0, readyOut}, 32'd0);
    // R9 writes ignored while running
    busWrite(12'h000, 8'hF0);
    check("R9 reset ignored in erase", {31'b0, readyOut}, 32'd0);
    // R8 status while busy
    busRead(12'h000, prev);
    check("R8 bit7 busy", {31'b0, prev[7]}, 32'd0);
    check("R8 other bits", {16'b0, prev & 16'hFFBF}, 32'd0);
    polls = 0;
    d = prev;
    while (d[7] == 1'b0 && polls < 100) begin
      busRead(12'h000, d);
      if (d[7] == 1'b0) begin
        check("R8 toggle", {31'b0, d[6]}, {31'b0, ~prev[6]});
        check("R8 other bits", {16'b0, d & 16'hFFBF}, 32'd0);
        prev = d;
      end
      polls++;
    end
    check("R9 completion seen", {31'b0, d[7]}, 32'd1);
    check("R9 ready after erase", {31'b0, readyOut}, 32'd1);
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    for (int i = 0; i < DEPTH; i++) begin
      busRead(12'(i), d);
      check("R9 all ones", {16'b0, d}, {16'b0, model[i]});
    end

    // R11 forced timeout
    forceTimeout = 1'b1;
    eraseSeq();
    repeat (TIMEOUT_CYC + 10) @(negedge clk);
    busRead(12'h000, prev);
    check("R11 timeout bit5", {31'b0, prev[5]}, 32'd1);
    check("R11 bit7 low", {31'b0, prev[7]}, 32'd0);
    check("R11 ready low", {31'b0, readyOut}, 32'd0);
    busRead(12'h000, d);
    check("R11 toggle", {31'b0, d[6]}, {31'b0, ~prev[6]});
    forceTimeout = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 stays failed", {31'b0, readyOut}, 32'd0);
    busWrite(12'h000, 8'hF0);
    check("R5 reset after fail", {31'b0, readyOut}, 32'd1);

    // R10 array left at zero by the pre-program pass
    for (int i = 0; i < DEPTH; i++) model[i] = 16'h0000;
    for (int n = 0; n < 10; n++) begin
      int a;
      a = $urandom % DEPTH;
      wordMode = $urandom % 2;
      busRead(12'(a), d);
      check("R10 zeroed array", {16'b0, d}, {16'b0, widthMask(model[a], wordMode)});
    end

    finishRun();
  end

endmodule